// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital sequencer of a multi-channel simultaneous-sampling converter running from an external conversion clock. All channels are sampled together while the start strobe `start_n` is low. The rising edge of `start_n` is the sampling instant. Conversion then proceeds as the external clock `conv_clk` toggles. Channel results become readable one after another at a fixed clock count. The block reports each one with a low pulse on `eoc_n`, and reports the final one with `eolc_n`.

A host reads the results over a chip-select/read-strobe parallel bus. The bus returns them in ascending order of the enabled channels. The raw 12-bit results come from a stub input, `chan_data`. All inputs are sampled on the system clock `clk`. Edges are detected inside the block, and every output reacts on the first `clk` edge at which an input change is seen.

The controller has four states:

- `ST_IDLE`: after reset.
- `ST_ACQ`: tracking while `start_n` is low.
- `ST_CONV`: counting conversion clocks.
- `ST_DONE`: all enabled results ready.

The transitions are:

- **acquire**: a falling edge of `start_n` moves any state to `ST_ACQ`.
- **launch**: a rising edge of `start_n` moves `ST_ACQ` to `ST_CONV`.
- **empty**: a rising edge of `start_n` with a zero mask moves `ST_ACQ` to `ST_DONE`.
- **finish**: the last enabled result moves `ST_CONV` to `ST_DONE`.

Top module: `simsamp_sequencer`

## Requirements
- R1: While `start_n` is low, `eoc_n` stays high and conversion-clock rising edges are not counted. The count begins only after `start_n` rises.
- R2: The first result is ready when the 13th rising edge of `conv_clk` after the `start_n` rise is seen. At that edge `eoc_n` goes low.
- R3: Each later result is ready 3 conversion-clock rising edges after the previous one. Exactly one result, and one `eoc_n` pulse, occurs per enabled channel. None follows the last.
- R4: Each `eoc_n` low pulse ends at the next `conv_clk` rising edge, so it lasts one conversion clock.
- R5: `eolc_n` goes low together with the `eoc_n` pulse of the final enabled channel. It stays low until the next falling edge of `start_n`.
- R6: A falling edge of `start_n` during conversion abandons it. `eoc_n` and `eolc_n` return high, the read position returns to the first enabled channel, and the next rise restarts the 13-edge count.
- R7: A start with an all-zero `chan_mask` (bit i enables channel i, latched at the `start_n` rise) makes `eolc_n` go low at once and produces no `eoc_n` pulse.
- R8: A read is active while `cs_n` and `rd_n` are both low. Each new activation drives the next unread ready result onto `data_out`, lowest enabled channel first. Channel i is taken from `chan_data[i*12 +: 12]`. This holds with `cs_n` held low, with `cs_n` framing each read, and with `cs_n` tied to `rd_n`.
- R9: An activation when no unread result is ready repeats the previously presented value and does not advance the read position.
- R10: `data_out` is zero whenever `cs_n` or `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Start strobe: low acquires, rise samples and starts |
| conv_clk | input | 1 | External conversion clock |
| chan_mask | input | NCH | Channel enable mask, bit i = channel i |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| chan_data | input | NCH*DW | Stub per-channel results |
| eoc_n | output | 1 | End-of-conversion pulse, active low |
| eolc_n | output | 1 | End-of-last-conversion flag, active low |
| data_out | output | DW | Parallel read data |

## Verification
The bench targets several timing and read-out corners:

- **Off-by-one clock counting.** It counts conversion clocks exactly around the 13th edge and the 3-edge stride. An off-by-one counter would move the first pulse to edge 12 or 14.
- **Acquisition-time clocks.** It toggles `conv_clk` while `start_n` is low. A design that counts these clocks would report its first result early.
- **Mid-conversion abort.** It aborts a conversion after one result. A design that keeps its stride counter or read pointer would pulse too early afterwards, or return a later channel first.
- **Reads versus results.** It interleaves reads with ongoing conversion and reads past the available results. A design that advances on an empty read would skip a channel.
- **Chip-select usage and zero mask.** It repeats reads under all three chip-select usages and with an empty mask.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/simsamp_edge.sv
module simsamp_edge #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev[i] <= RST_VAL[i];
            else        prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/simsamp_timer.sv
module simsamp_timer #(
    parameter int FIRST  = 13,
    parameter int STRIDE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output logic hit
);
    localparam int MAXV = (FIRST > STRIDE) ? FIRST : STRIDE;
    localparam int TW   = $clog2(MAXV + 1);

    logic [TW-1:0] tick;

    assign hit = advance && (tick == TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick <= TW'(FIRST);
        else if (load)    tick <= TW'(FIRST);
        else if (hit)     tick <= TW'(STRIDE);
        else if (advance) tick <= tick - 1'b1;
    end
endmodule

// File: rtl/simsamp_readout.sv
module simsamp_readout #(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [NCH-1:0]    mask,
    input  logic [$clog2(NCH+1)-1:0] ready_cnt,
    input  logic              rd_edge,
    input  logic              rd_active,
    input  logic [NCH*DW-1:0] chan_data,
    output logic [DW-1:0]     data_out
);
    localparam int CW = $clog2(NCH + 1);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CW-1:0] rd_ptr;
    logic [DW-1:0] held;
    logic [IW-1:0] sel;

    function automatic logic [IW-1:0] nth_chan(input logic [NCH-1:0] m,
                                               input logic [CW-1:0]  k);
        logic [CW-1:0] seen;
        nth_chan = '0;
        seen     = '0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                if (seen == k) nth_chan = IW'(i);
                seen = seen + 1'b1;
            end
        end
    endfunction

    assign sel = nth_chan(mask, rd_ptr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            held   <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
        end else if (rd_edge && (rd_ptr < ready_cnt)) begin
            held   <= chan_data[sel*DW +: DW];
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign data_out = rd_active ? held : '0;
endmodule

// File: rtl/simsamp_sequencer.sv
module simsamp_sequencer
    import simsamp_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DW     = 12,
    parameter int FIRST  = 13,
    parameter int STRIDE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              conv_clk,
    input  logic [NCH-1:0]    chan_mask,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [NCH*DW-1:0] chan_data,
    output logic              eoc_n,
    output logic              eolc_n,
    output logic [DW-1:0]     data_out
);
    localparam int CW = $clog2(NCH + 1);

    seq_state_e    state, state_nx;
    logic [2:0]    rise, fall;
    logic          start_rise, start_fall, cclk_rise, rd_edge, rd_active;
    logic          hit, last_hit;
    logic [NCH-1:0] mask_q;
    logic [CW-1:0] ready_cnt, nen_q, nen_now;

    assign rd_active = !cs_n && !rd_n;

    simsamp_edge #(.W(3), .RST_VAL(3'b001)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({rd_active, conv_clk, start_n}),
        .rise (rise),
        .fall (fall)
    );

    assign start_rise = rise[0];
    assign start_fall = fall[0];
    assign cclk_rise  = rise[1];
    assign rd_edge    = rise[2];
    assign nen_now    = CW'($countones(chan_mask));

    simsamp_timer #(.FIRST(FIRST), .STRIDE(STRIDE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_rise),
        .advance(cclk_rise && (state == ST_CONV)),
        .hit    (hit)
    );

    assign last_hit = hit && (ready_cnt + 1'b1 == nen_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state
    always_comb begin
        state_nx = state;
        if (start_fall) begin
            state_nx = ST_ACQ;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ACQ:  if (start_rise) state_nx = (nen_now == '0) ? ST_DONE : ST_CONV;
                ST_CONV: if (last_hit)   state_nx = ST_DONE;
                ST_DONE: state_nx = ST_DONE;
            endcase
        end
    end

    // outputs and conversion bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_n     <= 1'b1;
            eolc_n    <= 1'b1;
            ready_cnt <= '0;
            nen_q     <= '0;
            mask_q    <= '0;
        end else if (start_fall) begin
            eoc_n     <= 1'b1;
            eolc_n    <= 1'b1;
            ready_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ACQ: if (start_rise) begin
                    mask_q    <= chan_mask;
                    nen_q     <= nen_now;
                    ready_cnt <= '0;
                    if (nen_now == '0) eolc_n <= 1'b0;
                end
                ST_CONV: if (cclk_rise) begin
                    if (hit) begin
                        eoc_n     <= 1'b0;
                        ready_cnt <= ready_cnt + 1'b1;
                        if (last_hit) eolc_n <= 1'b0;
                    end else begin
                        eoc_n <= 1'b1;
                    end
                end
                ST_DONE: if (cclk_rise) eoc_n <= 1'b1;
            endcase
        end
    end

    simsamp_readout #(.NCH(NCH), .DW(DW)) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_fall),
        .mask     (mask_q),
        .ready_cnt(ready_cnt),
        .rd_edge  (rd_edge),
        .rd_active(rd_active),
        .chan_data(chan_data),
        .data_out (data_out)
    );
endmodule

// File: rtl/simsamp_sequencer_chk.sv
module simsamp_sequencer_chk
    import simsamp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_n,
    input logic                     conv_clk,
    input logic                     cs_n,
    input logic                     rd_n,
    input logic                     eoc_n,
    input logic                     eolc_n,
    input logic [DW-1:0]            data_out,
    input seq_state_e               state,
    input logic [$clog2(NCH+1)-1:0] ready_cnt,
    input logic [$clog2(NCH+1)-1:0] nen_q
);
    logic cc_q, st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q <= 1'b0;
            st_q <= 1'b1;
        end else begin
            cc_q <= conv_clk;
            st_q <= start_n;
        end
    end

    assert_eoc_in_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(state) == ST_CONV);

    assert_ready_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_cnt <= nen_q);

    assert_eoc_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_n && !(conv_clk && !cc_q) && !(!start_n && st_q)) |=> !eoc_n);

    assert_eolc_with_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(eolc_n) && nen_q != '0) |-> !eoc_n);

    assert_eolc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!eolc_n && start_n) |=> !eolc_n);

    assert_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> data_out == '0);
endmodule

bind simsamp_sequencer simsamp_sequencer_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .conv_clk (conv_clk),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .eoc_n    (eoc_n),
    .eolc_n   (eolc_n),
    .data_out (data_out),
    .state    (state),
    .ready_cnt(ready_cnt),
    .nen_q    (nen_q)
);

// File: tb/simsamp_sequencer_test.sv
module simsamp_sequencer_test;
    localparam int NCH = 8;
    localparam int DW  = 12;

    logic              clk = 1'b0;
    logic              rst_n, start_n, conv_clk, cs_n, rd_n;
    logic [NCH-1:0]    chan_mask;
    logic [NCH*DW-1:0] chan_data;
    logic              eoc_n, eolc_n;
    logic [DW-1:0]     data_out;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    int            age = 0;

    always #2 clk = ~clk;

    simsamp_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .conv_clk(conv_clk),
        .chan_mask(chan_mask), .cs_n(cs_n), .rd_n(rd_n), .chan_data(chan_data),
        .eoc_n(eoc_n), .eolc_n(eolc_n), .data_out(data_out)
    );

    function automatic logic [DW-1:0] chv(input int i);
        return DW'(12'hA05 + i * 12'h013);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic conv_pulse();
        conv_clk = 1'b1; tick(2);
        conv_clk = 1'b0; tick(2);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) conv_pulse();
    endtask

    // mode 0: cs_n already low, 1: cs_n frames rd_n, 2: cs_n tied to rd_n
    task automatic do_read(input int mode, input logic [DW-1:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        if (mode == 1) begin cs_n = 1'b0; tick(1); end
        if (mode == 2) cs_n = 1'b0;
        rd_n = 1'b0;
        tick(3);
        rd_n = 1'b1;
        if (mode != 0) cs_n = 1'b1;
        tick(2);
        check("R10 bus idle", data_out, '0);
    endtask

    task automatic restart();
        start_n = 1'b0; tick(2);
        start_n = 1'b1; tick(2);
    endtask

    // monitor: compares presented data with the scoreboard queue
    always @(negedge clk) begin
        if (!cs_n && !rd_n) age++;
        else age = 0;
        if (age == 2) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R8: actual %h expected none", data_out);
            end else begin
                check(tag_q.pop_front(), data_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_n = 1'b1; conv_clk = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        chan_mask = '0;
        for (int i = 0; i < NCH; i++) chan_data[i*DW +: DW] = chv(i);
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R5 reset eolc", DW'(eolc_n), 1);
        check("R4 reset eoc", DW'(eoc_n), 1);
        check("R10 reset bus", data_out, '0);

        // Test A: channels 0 and 2, clocks during acquisition ignored
        chan_mask = 8'b0000_0101;
        start_n = 1'b0; tick(2);
        pulses(3);
        check("R1 eoc while acquiring", DW'(eoc_n), 1);
        start_n = 1'b1; tick(2);
        pulses(12);
        check("R1 R2 no eoc at edge 12", DW'(eoc_n), 1);
        conv_pulse();
        check("R2 eoc at edge 13", DW'(eoc_n), 0);
        check("R5 eolc high mid", DW'(eolc_n), 1);
        conv_pulse();
        check("R4 eoc one clock", DW'(eoc_n), 1);
        conv_pulse();
        check("R3 no eoc at stride-1", DW'(eoc_n), 1);
        conv_pulse();
        check("R3 eoc at stride", DW'(eoc_n), 0);
        check("R5 eolc at last", DW'(eolc_n), 0);
        conv_pulse();
        check("R4 last eoc ends", DW'(eoc_n), 1);
        for (int k = 0; k < 6; k++) begin
            conv_pulse();
            check("R3 no extra eoc", DW'(eoc_n), 1);
        end
        cs_n = 1'b0;
        do_read(0, chv(0), "R8 cs held low ch0");
        do_read(0, chv(2), "R8 cs held low ch2");
        cs_n = 1'b1;
        do_read(1, chv(2), "R9 read past end");
        check("R5 eolc held", DW'(eolc_n), 0);
        start_n = 1'b0; tick(2);
        check("R5 eolc release", DW'(eolc_n), 1);

        // Test B: channels 1,2,5,7 with reads during conversion
        chan_mask = 8'b1010_0110;
        start_n = 1'b1; tick(2);
        pulses(13);
        check("R2 first of four", DW'(eoc_n), 0);
        do_read(2, chv(1), "R8 cs tied ch1");
        do_read(2, chv(1), "R9 no new result");
        pulses(3);
        check("R3 second of four", DW'(eoc_n), 0);
        check("R5 eolc not yet", DW'(eolc_n), 1);
        do_read(1, chv(2), "R8 cs framed ch2");
        pulses(6);
        check("R5 eolc after fourth", DW'(eolc_n), 0);
        do_read(1, chv(5), "R8 ch5");
        do_read(2, chv(7), "R8 ch7");

        // Test C: abort after one result
        chan_mask = 8'b0001_1000;
        restart();
        pulses(14);
        start_n = 1'b0; tick(2);
        check("R6 abort eoc", DW'(eoc_n), 1);
        check("R6 abort eolc", DW'(eolc_n), 1);
        pulses(2);
        start_n = 1'b1; tick(2);
        pulses(12);
        check("R6 count restarted", DW'(eoc_n), 1);
        conv_pulse();
        check("R6 eoc after restart", DW'(eoc_n), 0);
        do_read(1, chv(3), "R6 pointer cleared ch3");
        pulses(3);
        check("R5 eolc ch4", DW'(eolc_n), 0);
        do_read(1, chv(4), "R8 ch4");

        // Test D: empty mask
        chan_mask = '0;
        restart();
        check("R7 eolc immediate", DW'(eolc_n), 0);
        for (int k = 0; k < 20; k++) begin
            conv_pulse();
            if (eoc_n !== 1'b1) check("R7 no eoc", DW'(eoc_n), 1);
        end
        check("R7 no eoc end", DW'(eoc_n), 1);

        tick(4);
        check("R8 scoreboard drained", DW'(exp_q.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule